// File: doc/BRIEF.md
# Hamming SECDED Nibble Codec

This block protects 4-bit data nibbles with a single-error-correcting, double-error-detecting code. The encoder side turns a nibble into an 8-bit protected word. The decoder side takes a received 8-bit word and returns four things: the repaired nibble, the check syndrome, a flag for a corrected single error and a flag for an uncorrectable double error.

Each side has one register stage with its own valid strobe. A write path feeds the encoder, and a read path feeds the decoder. Bits 1 through 7 of the protected word hold code positions 1 through 7, and the check bits sit at the power-of-two positions. Because of this layout, a non-zero syndrome is the position of the failing bit. Bit 0 holds an overall parity bit. It lets the decoder tell a single flip apart from a double flip.

Top module: `secded_codec`

## Requirements
- R1: Encoded bit k (k = 1..7) is code position k. The nibble's MSB goes to position 3, the next bit to position 5, the next to position 6 and the LSB to position 7. Nibble 1011 encodes to 8'hCC.
- R2: The check bit at position 1 is even parity over positions 3, 5 and 7. The check bit at position 2 is even parity over positions 3, 6 and 7. The check bit at position 4 is even parity over positions 5, 6 and 7.
- R3: Encoded bit 0 is set so that all 8 bits of the word have even parity.
- R4: enc_valid_o rises exactly one clock after enc_valid_i is sampled high, and is low one clock after it is sampled low.
- R5: dec_valid_o follows dec_valid_i with exactly one clock of latency.
- R6: dec_syndrome_o is the 3-bit value {s4,s2,s1}. Here s1 is the XOR of received positions 1, 3, 5 and 7, s2 is the XOR of positions 2, 3, 6 and 7, and s4 is the XOR of positions 4, 5, 6 and 7.
- R7: A valid codeword decodes to its nibble with both flags low and a syndrome of 0.
- R8: A single flip at position 1..7 gives dec_corrected_o=1 and dec_double_o=0, the syndrome equals the position, and the original nibble is returned. For example, 8'hCC with position 6 flipped returns 1011 with syndrome 6.
- R9: A flip of bit 0 alone gives syndrome 0, dec_corrected_o=1 and dec_double_o=0, and the nibble is unchanged.
- R10: Any two flipped bits give dec_double_o=1 and dec_corrected_o=0. The nibble is passed through uncorrected, read from received positions 3, 5, 6 and 7.
- R11: While rst_ni is low, both valid outputs are 0.
- R12: While a side's valid input is low, that side's data, syndrome and flag outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enc_valid_i | input | 1 | Encoder input strobe |
| enc_data_i | input | 4 | Nibble to protect |
| enc_valid_o | output | 1 | Encoder output strobe |
| enc_code_o | output | 8 | Protected word; bit 0 is overall parity |
| dec_valid_i | input | 1 | Decoder input strobe |
| dec_code_i | input | 8 | Received word |
| dec_valid_o | output | 1 | Decoder output strobe |
| dec_data_o | output | 4 | Repaired nibble |
| dec_syndrome_o | output | 3 | Check syndrome {s4,s2,s1} |
| dec_corrected_o | output | 1 | Single error found and corrected |
| dec_double_o | output | 1 | Uncorrectable double error |

## Verification
The only state in the block is the output registers, so a wrong capture shows at the ports one clock after the strobe. A bad capture is a stale nibble, a stuck flag or a missing valid pulse. A fault in the syndrome logic shows as a wrong syndrome value. It also shows as a wrong classification on the single-flip or double-flip patterns that touch the affected position. Every nibble is run with every one- and two-bit corruption, so a mis-wired check term or position cannot stay hidden for more than a few hundred cycles.

// File: rtl/secded_pkg.sv
`timescale 1ns/1ps
package secded_pkg;
  localparam int PAR_W  = 3;
  localparam int N_POS  = (1 << PAR_W) - 1;
  localparam int DATA_W = N_POS - PAR_W;
  localparam int CODE_W = N_POS + 1;

  typedef logic [DATA_W-1:0] data_t;
  typedef logic [CODE_W-1:0] code_t;
  typedef logic [PAR_W-1:0]  syn_t;

  function automatic logic is_pow2(input int p);
    return (p & (p - 1)) == 0;
  endfunction

  // data MSB lands on the lowest non-power-of-two position
  function automatic code_t place_data(input data_t d);
    code_t w;
    int    k;
    w = '0;
    k = DATA_W - 1;
    for (int pos = 1; pos <= N_POS; pos++) begin
      if (!is_pow2(pos)) begin
        w[pos] = d[k];
        k--;
      end
    end
    return w;
  endfunction

  function automatic data_t pick_data(input code_t w);
    data_t d;
    int    k;
    d = '0;
    k = DATA_W - 1;
    for (int pos = 1; pos <= N_POS; pos++) begin
      if (!is_pow2(pos)) begin
        d[k] = w[pos];
        k--;
      end
    end
    return d;
  endfunction

  // XOR of all positions whose index has bit j set
  function automatic logic check_xor(input code_t w, input int j);
    logic x;
    x = 1'b0;
    for (int pos = 1; pos <= N_POS; pos++) begin
      if (((pos >> j) & 1) == 1) x = x ^ w[pos];
    end
    return x;
  endfunction
endpackage

// File: rtl/secded_enc_stage.sv
`timescale 1ns/1ps
module secded_enc_stage
  import secded_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  valid_i,
  input  data_t data_i,
  output logic  valid_o,
  output code_t code_o
);
  code_t            placed;
  logic [PAR_W-1:0] par;
  code_t            word;

  assign placed = place_data(data_i);

  for (genvar j = 0; j < PAR_W; j++) begin : g_par
    assign par[j] = check_xor(placed, j);
  end

  always_comb begin
    word = placed;
    for (int j = 0; j < PAR_W; j++) word[1 << j] = par[j];
    word[0] = ^word[N_POS:1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      code_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) code_o <= word;
    end
  end

  a_r4_enc_latency_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r4_enc_latency_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r3_enc_even_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (^code_o) == 1'b0);
  a_r1_enc_data_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> pick_data(code_o) == $past(data_i));
  a_r12_enc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(code_o));
endmodule

// File: rtl/secded_dec_stage.sv
`timescale 1ns/1ps
module secded_dec_stage
  import secded_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  valid_i,
  input  code_t code_i,
  output logic  valid_o,
  output data_t data_o,
  output syn_t  syndrome_o,
  output logic  corrected_o,
  output logic  double_o
);
  syn_t  syn;
  logic  par_err;
  logic  syn_nz;
  code_t fix;
  data_t data_c;
  logic  single_c;
  logic  double_c;

  for (genvar j = 0; j < PAR_W; j++) begin : g_syn
    assign syn[j] = check_xor(code_i, j);
  end

  assign par_err  = ^code_i;
  assign syn_nz   = |syn;
  assign single_c = par_err;             // covers overall-bit flip (syn==0) too
  assign double_c = syn_nz && !par_err;

  always_comb begin
    fix = '0;
    if (syn_nz && par_err) fix[syn] = 1'b1;
    data_c = pick_data(code_i ^ fix);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      data_o      <= '0;
      syndrome_o  <= '0;
      corrected_o <= 1'b0;
      double_o    <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        data_o      <= data_c;
        syndrome_o  <= syn;
        corrected_o <= single_c;
        double_o    <= double_c;
      end
    end
  end

  a_r5_dec_latency_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r5_dec_latency_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r10_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !(corrected_o && double_o));
  a_r7_clean_no_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && syndrome_o == '0 && !corrected_o |-> !double_o);
  a_r12_dec_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(data_o) && $stable(syndrome_o) &&
                 $stable(corrected_o) && $stable(double_o));
endmodule

// File: rtl/secded_codec.sv
`timescale 1ns/1ps
module secded_codec
  import secded_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       enc_valid_i,
  input  logic [3:0] enc_data_i,
  output logic       enc_valid_o,
  output logic [7:0] enc_code_o,
  input  logic       dec_valid_i,
  input  logic [7:0] dec_code_i,
  output logic       dec_valid_o,
  output logic [3:0] dec_data_o,
  output logic [2:0] dec_syndrome_o,
  output logic       dec_corrected_o,
  output logic       dec_double_o
);
  secded_enc_stage u_enc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (enc_valid_i),
    .data_i  (enc_data_i),
    .valid_o (enc_valid_o),
    .code_o  (enc_code_o)
  );

  secded_dec_stage u_dec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (dec_valid_i),
    .code_i      (dec_code_i),
    .valid_o     (dec_valid_o),
    .data_o      (dec_data_o),
    .syndrome_o  (dec_syndrome_o),
    .corrected_o (dec_corrected_o),
    .double_o    (dec_double_o)
  );

  a_r11_reset_valids: assert property (@(posedge clk_i)
    !rst_ni |-> !enc_valid_o && !dec_valid_o);
endmodule

// File: tb/secded_codec_tb.sv
`timescale 1ns/1ps
module secded_codec_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       enc_valid_i = 1'b0;
  logic [3:0] enc_data_i = '0;
  logic       enc_valid_o;
  logic [7:0] enc_code_o;
  logic       dec_valid_i = 1'b0;
  logic [7:0] dec_code_i = '0;
  logic       dec_valid_o;
  logic [3:0] dec_data_o;
  logic [2:0] dec_syndrome_o;
  logic       dec_corrected_o;
  logic       dec_double_o;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  secded_codec u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .enc_valid_i(enc_valid_i), .enc_data_i(enc_data_i),
    .enc_valid_o(enc_valid_o), .enc_code_o(enc_code_o),
    .dec_valid_i(dec_valid_i), .dec_code_i(dec_code_i),
    .dec_valid_o(dec_valid_o), .dec_data_o(dec_data_o),
    .dec_syndrome_o(dec_syndrome_o), .dec_corrected_o(dec_corrected_o),
    .dec_double_o(dec_double_o)
  );

  // fields: code[16:9] data[8:5] syn[4:2] corr[1] dbl[0]
  localparam logic [16:0] VEC [5] = '{
    {8'hCC, 4'hB, 3'd0, 1'b0, 1'b0},  // R7 clean
    {8'h8C, 4'hB, 3'd6, 1'b1, 1'b0},  // R8 position 6 flipped
    {8'hCD, 4'hB, 3'd0, 1'b1, 1'b0},  // R9 overall bit flipped
    {8'h8D, 4'h9, 3'd6, 1'b0, 1'b1},  // R10 bits 0 and 6 flipped
    {8'h00, 4'h0, 3'd0, 1'b0, 1'b0}   // R7 all zero
  };

  function automatic logic [7:0] ref_enc(input logic [3:0] d);
    logic [7:0] w;
    logic p1, p2, p4;
    p1 = d[3] ^ d[2] ^ d[0];
    p2 = d[3] ^ d[1] ^ d[0];
    p4 = d[2] ^ d[1] ^ d[0];
    w[7:1] = {d[0], d[1], d[2], p4, d[3], p2, p1};
    w[0] = ^w[7:1];
    return w;
  endfunction

  function automatic logic [3:0] raw_data(input logic [7:0] w);
    return {w[3], w[5], w[6], w[7]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic dec_run(input logic [7:0] cw, input string req, input logic [3:0] ed,
                         input logic [2:0] es, input logic ec, input logic eb);
    @(negedge clk);
    dec_valid_i = 1'b1;
    dec_code_i  = cw;
    @(negedge clk);
    dec_valid_i = 1'b0;
    chk(req, {dec_valid_o, dec_data_o, dec_syndrome_o, dec_corrected_o, dec_double_o},
             {1'b1, ed, es, ec, eb});
  endtask

  task automatic enc_run(input logic [3:0] d);
    @(negedge clk);
    enc_valid_i = 1'b1;
    enc_data_i  = d;
    @(negedge clk);
    enc_valid_i = 1'b0;
    chk("R1 R2 R3 R4 encode", {enc_valid_o, enc_code_o}, {1'b1, ref_enc(d)});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [3:0]  hd;
    logic [2:0]  hs;
    logic        hc, hb;
    logic [7:0]  hcode;
    repeat (3) @(negedge clk);
    chk("R11 reset valids", {enc_valid_o, dec_valid_o}, 2'b00);
    rst_ni = 1'b1;

    for (int i = 0; i < 5; i++)
      dec_run(VEC[i][16:9], "R6 R7 R8 R9 R10 table", VEC[i][8:5], VEC[i][4:2],
              VEC[i][1], VEC[i][0]);

    enc_run(4'hB);
    chk("R1 nibble 1011", enc_code_o, 8'hCC);

    for (int d = 0; d < 16; d++) begin
      logic [7:0] cw;
      cw = ref_enc(4'(d));
      enc_run(4'(d));
      dec_run(cw, "R7 clean", 4'(d), 3'd0, 1'b0, 1'b0);
      for (int a = 0; a < 8; a++) begin
        if (a == 0)
          dec_run(cw ^ 8'h01, "R9 overall flip", 4'(d), 3'd0, 1'b1, 1'b0);
        else
          dec_run(cw ^ (8'h01 << a), "R8 single flip", 4'(d), 3'(a), 1'b1, 1'b0);
        for (int b = a + 1; b < 8; b++) begin
          logic [7:0] bad;
          bad = cw ^ (8'h01 << a) ^ (8'h01 << b);
          dec_run(bad, "R10 double flip", raw_data(bad), 3'(a ^ b), 1'b0, 1'b1);
        end
      end
    end

    // R12: outputs hold while valid is low
    dec_run(8'h8C, "R8 before hold", 4'hB, 3'd6, 1'b1, 1'b0);
    enc_run(4'h5);
    hd = dec_data_o; hs = dec_syndrome_o; hc = dec_corrected_o; hb = dec_double_o;
    hcode = enc_code_o;
    @(negedge clk);
    dec_code_i = 8'hFF;
    enc_data_i = 4'hA;
    @(negedge clk);
    @(negedge clk);
    chk("R12 hold decode", {dec_valid_o, dec_data_o, dec_syndrome_o, dec_corrected_o, dec_double_o},
        {1'b0, hd, hs, hc, hb});
    chk("R12 hold encode", {enc_valid_o, enc_code_o}, {1'b0, hcode});
    chk("R5 dec valid drops", dec_valid_o, 1'b0);

    // R11: asynchronous reset during activity
    @(negedge clk);
    enc_valid_i = 1'b1;
    dec_valid_i = 1'b1;
    @(negedge clk);
    chk("R4 R5 valids high", {enc_valid_o, dec_valid_o}, 2'b11);
    #3 rst_ni = 1'b0;
    #2;
    chk("R11 reset mid-run", {enc_valid_o, dec_valid_o}, 2'b00);
    enc_valid_i = 1'b0;
    dec_valid_i = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule